// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a four-bank synchronous DRAM refreshed without stalling the host more often than it must. An interval timer adds one owed refresh every average refresh period. The owed count is a debt, capped at eight. While the host is requesting or using the command bus, refreshes are postponed and the debt grows. When the host falls quiet, or when the debt reaches its cap, the scheduler takes the bus, closes any open rows with a precharge-all, waits the precharge time, and then issues refresh commands one after another until the debt is paid or the host asks for the bus again.

The host-side arbiter sees two signals. The grant is high while the scheduler leaves the bus alone. The busy flag is high while the scheduler owns the bus. Once the debt reaches its cap the grant drops, so that no new host transaction begins. The scheduler waits for the host's current transaction to end and then starts refreshing. The command pins are active-low chip select, row strobe, column strobe and write enable, plus the address bit that selects all banks for a precharge. No other address is driven, because the memory's own row counter supplies the refresh row.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, the pins show the no-operation command, grant is high and busy is low.
- R2: The debt grows by one every REFI_CYC clock cycles from reset and never exceeds MAX_DEBT. A tick that arrives while the debt is at the cap is lost.
- R3: Whenever the scheduler is not issuing a command, the pins carry no-operation: {cs_n,ras_n,cas_n,we_n} = 4'b0111 and a10 low.
- R4: If any bit of bank_open is set when a refresh sequence starts, a precharge-all ({cs_n,ras_n,cas_n,we_n} = 4'b0010, a10 high) is driven for one cycle. The refresh follows exactly TRP_CYC cycles later.
- R5: If no bank is open when a sequence starts, no precharge is driven. The refresh appears in the cycle after the decision.
- R6: A refresh is driven as {cs_n,ras_n,cas_n,we_n} = 4'b0001 for exactly one cycle, and it pays off one unit of debt.
- R7: Two refresh commands are at least TRFC_CYC cycles apart. Busy stays high from the first command of a sequence until TRFC_CYC-1 cycles after its refresh.
- R8: When the debt is non-zero and the host neither requests nor uses the bus, the scheduler starts a refresh sequence in the next cycle.
- R9: While host_req is high and the debt is below the cap, no sequence starts and grant stays high.
- R10: When the debt is at the cap and the scheduler is idle, grant is low and host_req is ignored.
- R11: No sequence starts in a cycle in which host_busy is high.
- R12: With the host quiet and the debt at the cap, the owed refreshes are issued back to back, every TRFC_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host wants the command bus for a new transaction |
| host_busy | input | 1 | Host is in the middle of a transaction; the bus cannot be taken |
| bank_open | input | NUM_BANKS | One bit per bank with an open row |
| host_gnt | output | 1 | The host may start a transaction |
| ref_busy | output | 1 | The scheduler owns the command bus |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | All-bank select during precharge |

## Verification
The bench goes after several corner cases. It drives the debt into saturation and keeps it there while ticks are lost. A design that let the debt wrap would issue too few refreshes afterwards, and one that only fired on the cap would refresh late. It holds host_busy high while the grant is down to confirm that a forced refresh waits for the end of the transaction and does not cut into it. It also compares sequences with open and with closed banks: a wrong design would skip the precharge wait or insert a needless one. After a long postponement it measures every gap in the drain. An off-by-one in the cycle wait would show up as a gap shorter than the refresh cycle time or as lost back-to-back throughput.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PRE      = 3'd1,
        ST_WAIT_RP  = 3'd2,
        ST_REF      = 3'd3,
        ST_WAIT_RFC = 3'd4
    } ref_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam sd_cmd_t CMD_PRE_ALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam sd_cmd_t CMD_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

    function automatic sd_cmd_t cmd_for_state(input ref_state_e st);
        sd_cmd_t c;
        case (st)
            ST_PRE:  c = CMD_PRE_ALL;
            ST_REF:  c = CMD_REFRESH;
            default: c = CMD_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int unsigned REFI_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CNT_W = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REFI_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        tick = (r_q.cnt == LAST);
        if (tick) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter #(
    parameter int unsigned MAX_DEBT = 8,
    localparam int unsigned DEBT_W  = $clog2(MAX_DEBT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pay,
    output logic [DEBT_W-1:0] debt,
    output logic              pending,
    output logic              full
);
    localparam logic [DEBT_W-1:0] CAP = DEBT_W'(MAX_DEBT);

    typedef struct packed {
        logic [DEBT_W-1:0] debt;
    } debt_t;

    debt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (tick && !pay) begin
            if (r_q.debt != CAP) begin
                r_d.debt = r_q.debt + DEBT_W'(1);
            end
        end else if (!tick && pay) begin
            if (r_q.debt != '0) begin
                r_d.debt = r_q.debt - DEBT_W'(1);
            end
        end
        debt    = r_q.debt;
        pending = (r_q.debt != '0);
        full    = (r_q.debt == CAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/ref_cmd_seq.sv
module ref_cmd_seq
    import sdram_ref_pkg::*;
#(
    parameter int unsigned TRP_CYC   = 2,
    parameter int unsigned TRFC_CYC  = 4,
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pending,
    input  logic                 full,
    input  logic                 host_req,
    input  logic                 host_busy,
    input  logic [NUM_BANKS-1:0] bank_open,
    output sd_cmd_t              cmd,
    output logic                 ref_fire,
    output logic                 idle
);
    localparam int unsigned WAIT_MAX = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
    localparam int unsigned WAIT_W   = (WAIT_MAX > 2) ? $clog2(WAIT_MAX) : 1;
    localparam logic [WAIT_W-1:0] RP_LOAD  = WAIT_W'(TRP_CYC - 2);
    localparam logic [WAIT_W-1:0] RFC_LOAD = WAIT_W'(TRFC_CYC - 2);

    typedef struct packed {
        ref_state_e        st;
        logic [WAIT_W-1:0] wait_cnt;
    } seq_t;

    seq_t r_d, r_q;
    logic start;
    logic any_open;

    always_comb begin
        r_d      = r_q;
        any_open = |bank_open;
        // Take the bus when owed and the host is between transactions;
        // a pending host request only wins while the debt is below the cap.
        start    = pending && !host_busy && (!host_req || full);

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st = any_open ? ST_PRE : ST_REF;
                end
            end
            ST_PRE: begin
                r_d.st       = ST_WAIT_RP;
                r_d.wait_cnt = RP_LOAD;
            end
            ST_WAIT_RP: begin
                if (r_q.wait_cnt == '0) begin
                    r_d.st = ST_REF;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt - WAIT_W'(1);
                end
            end
            ST_REF: begin
                r_d.st       = ST_WAIT_RFC;
                r_d.wait_cnt = RFC_LOAD;
            end
            ST_WAIT_RFC: begin
                if (r_q.wait_cnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt - WAIT_W'(1);
                end
            end
            default: begin
                r_d.st       = ST_IDLE;
                r_d.wait_cnt = '0;
            end
        endcase

        cmd      = cmd_for_state(r_q.st);
        ref_fire = (r_q.st == ST_REF);
        idle     = (r_q.st == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.wait_cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
    import sdram_ref_pkg::*;
#(
    parameter int unsigned REFI_CYC  = 780,
    parameter int unsigned TRP_CYC   = 2,
    parameter int unsigned TRFC_CYC  = 4,
    parameter int unsigned MAX_DEBT  = 8,
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned DEBT_W   = $clog2(MAX_DEBT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_busy,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 host_gnt,
    output logic                 ref_busy,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic                 sd_a10
);
    logic              tick;
    logic              ref_fire;
    logic              pending;
    logic              full;
    logic              idle;
    logic [DEBT_W-1:0] debt_q;
    sd_cmd_t           cmd;

    ref_interval_timer #(
        .REFI_CYC (REFI_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ref_debt_counter #(
        .MAX_DEBT (MAX_DEBT)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .pay     (ref_fire),
        .debt    (debt_q),
        .pending (pending),
        .full    (full)
    );

    ref_cmd_seq #(
        .TRP_CYC   (TRP_CYC),
        .TRFC_CYC  (TRFC_CYC),
        .NUM_BANKS (NUM_BANKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .full      (full),
        .host_req  (host_req),
        .host_busy (host_busy),
        .bank_open (bank_open),
        .cmd       (cmd),
        .ref_fire  (ref_fire),
        .idle      (idle)
    );

    always_comb begin
        host_gnt = idle && !full;
        ref_busy = !idle;
        sd_cs_n  = cmd.cs_n;
        sd_ras_n = cmd.ras_n;
        sd_cas_n = cmd.cas_n;
        sd_we_n  = cmd.we_n;
        sd_a10   = cmd.a10;
    end
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
    parameter int unsigned TRFC_CYC = 4,
    parameter int unsigned MAX_DEBT = 8,
    parameter int unsigned DEBT_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_busy,
    input logic              host_gnt,
    input logic              ref_busy,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic              sd_a10,
    input logic [DEBT_W-1:0] debt
);
    logic [3:0]  pins;
    logic        is_ref;
    logic        is_pre;
    logic        is_nop;
    logic        seen_ref_q;
    logic [15:0] since_ref_q;

    assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_ref = (pins == 4'b0001);
    assign is_pre = (pins == 4'b0010);
    assign is_nop = (pins == 4'b0111);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_ref_q  <= 1'b0;
            since_ref_q <= '0;
        end else if (is_ref) begin
            seen_ref_q  <= 1'b1;
            since_ref_q <= 16'd1;
        end else if (since_ref_q != 16'hFFFF) begin
            since_ref_q <= since_ref_q + 16'd1;
        end
    end

    assert_debt_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DEBT_W'(MAX_DEBT));

    assert_nop_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_busy |-> (is_nop && !sd_a10));

    assert_pre_all_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_a10);

    assert_ref_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |=> is_nop);

    assert_ref_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && seen_ref_q) |-> (since_ref_q >= 16'(TRFC_CYC)));

    assert_gnt_low_only_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_busy && !host_gnt) |-> (debt == DEBT_W'(MAX_DEBT)));

    assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_busy && host_busy) |=> !ref_busy);
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
    .TRFC_CYC (TRFC_CYC),
    .MAX_DEBT (MAX_DEBT),
    .DEBT_W   (DEBT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_busy (host_busy),
    .host_gnt  (host_gnt),
    .ref_busy  (ref_busy),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_a10    (sd_a10),
    .debt      (debt_q)
);

// File: tb/sdram_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb;
    localparam int REFI = 100;
    localparam int TRP  = 3;
    localparam int TRFC = 6;
    localparam int MAXD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0;
    logic       host_busy = 1'b0;
    logic [3:0] bank_open = 4'b0000;
    logic       host_gnt, ref_busy;
    logic       sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;

    always #10 clk = ~clk;

    sdram_refresh_sched #(
        .REFI_CYC (REFI), .TRP_CYC (TRP), .TRFC_CYC (TRFC),
        .MAX_DEBT (MAXD), .NUM_BANKS (4)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .host_req (host_req), .host_busy (host_busy),
        .bank_open (bank_open), .host_gnt (host_gnt), .ref_busy (ref_busy),
        .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
        .sd_we_n (sd_we_n), .sd_a10 (sd_a10)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // behavioural reference: elapsed cycles, owed refreshes, and a timeline
    int m_elapsed = 0;
    int m_debt    = 0;
    int m_mode    = 0;   // 0 idle, 1 precharge, 2 rp wait, 3 refresh, 4 rfc wait
    int m_left    = 0;

    // observations from the pins
    int last_pre = -1000;
    int last_ref = -1000;
    int n_pre = 0;
    int n_ref = 0;
    int ref_times[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic model_step();
        bit tick;
        bit pay;
        m_elapsed++;
        tick = (m_elapsed % REFI) == 0;
        pay  = (m_mode == 3);
        if (m_mode == 0) begin
            if (m_debt > 0 && !host_busy && (!host_req || m_debt == MAXD))
                m_mode = (bank_open != 0) ? 1 : 3;
        end else if (m_mode == 1) begin
            m_mode = 2; m_left = TRP - 1;
        end else if (m_mode == 2) begin
            m_left--;
            if (m_left == 0) m_mode = 3;
        end else if (m_mode == 3) begin
            m_mode = 4; m_left = TRFC - 1;
        end else begin
            m_left--;
            if (m_left == 0) m_mode = 0;
        end
        m_debt = m_debt + (tick ? 1 : 0) - (pay ? 1 : 0);
        if (m_debt > MAXD) m_debt = MAXD;
    endtask

    function automatic int pins_now();
        return {27'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10};
    endfunction

    task automatic compare();
        int exp_pins;
        string tag;
        case (m_mode)
            1:       begin exp_pins = 5'b00101; tag = "R4 precharge-all"; end
            3:       begin exp_pins = 5'b00010; tag = "R6 refresh";       end
            default: begin exp_pins = 5'b01110; tag = "R3 nop";           end
        endcase
        chk(pins_now() == exp_pins, tag, pins_now(), exp_pins);
        chk(host_gnt == (m_mode == 0 && m_debt != MAXD), "R9/R10 grant",
            int'(host_gnt), int'(m_mode == 0 && m_debt != MAXD));
        chk(ref_busy == (m_mode != 0), "R7 busy", int'(ref_busy), int'(m_mode != 0));
    endtask

    task automatic observe();
        if (pins_now() == 5'b00101) begin
            last_pre = cyc; n_pre++;
        end
        if (pins_now() == 5'b00010) begin
            if (last_ref >= 0)
                chk(cyc - last_ref >= TRFC, "R7 refresh spacing", cyc - last_ref, TRFC);
            if (bank_open != 0)
                chk(cyc - last_pre == TRP, "R4 precharge to refresh", cyc - last_pre, TRP);
            last_ref = cyc; n_ref++;
            ref_times.push_back(cyc);
        end
    endtask

    task automatic step_cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc++;
        compare();
        observe();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step_cycle();
    endtask

    initial begin
        int pre0, ref0;
        bit gnt_seen_low;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pins_now() == 5'b01110, "R1 pins in reset", pins_now(), 5'b01110);
        chk(host_gnt == 1'b1, "R1 grant in reset", int'(host_gnt), 1);
        chk(ref_busy == 1'b0, "R1 busy in reset", int'(ref_busy), 0);
        rst_n = 1'b1;
        step_cycle();
        chk(pins_now() == 5'b01110 && host_gnt && !ref_busy, "R1 first cycle",
            pins_now(), 5'b01110);

        // R8 / R5: quiet host, closed banks
        pre0 = n_pre; ref0 = n_ref;
        run(260);
        chk(n_ref - ref0 == 2, "R8 refreshes when quiet", n_ref - ref0, 2);
        chk(n_pre - pre0 == 0, "R5 no precharge with closed banks", n_pre - pre0, 0);

        // R4: open banks force precharge-all first
        bank_open = 4'b0101;
        pre0 = n_pre; ref0 = n_ref;
        run(200);
        chk(n_pre - pre0 == 2, "R4 precharge count", n_pre - pre0, 2);
        chk(n_ref - ref0 == 2, "R4 refresh count", n_ref - ref0, 2);
        bank_open = 4'b0000;

        // R9: host keeps requesting, debt grows, no refresh
        host_req = 1'b1;
        ref0 = n_ref;
        run(700);
        chk(n_ref - ref0 == 0, "R9 postponed while requested", n_ref - ref0, 0);
        chk(host_gnt == 1'b1, "R9 grant kept below cap", int'(host_gnt), 1);

        // R11 / R10: host mid-transaction while the debt reaches the cap
        host_busy = 1'b1;
        gnt_seen_low = 0;
        for (int i = 0; i < 200; i++) begin
            step_cycle();
            if (!host_gnt) gnt_seen_low = 1;
        end
        chk(n_ref - ref0 == 0, "R11 no start while host busy", n_ref - ref0, 0);
        chk(gnt_seen_low, "R10 grant dropped at cap", int'(gnt_seen_low), 1);
        host_busy = 1'b0;
        run(TRFC + 4);
        chk(n_ref - ref0 == 1, "R10 forced refresh despite request", n_ref - ref0, 1);

        // R2 / R12: long saturation, then a full back-to-back drain
        host_busy = 1'b1;
        run(1200);
        host_busy = 1'b0;
        host_req  = 1'b0;
        ref_times.delete();
        run(8 * (TRFC + 1) + 20);
        chk(ref_times.size() >= MAXD, "R12 drained refresh count", ref_times.size(), MAXD);
        for (int k = 1; k < MAXD && k < ref_times.size(); k++)
            chk(ref_times[k] - ref_times[k-1] == TRFC + 1, "R12 back-to-back gap",
                ref_times[k] - ref_times[k-1], TRFC + 1);
        chk(ref_times.size() <= MAXD + 1, "R2 debt capped during saturation",
            ref_times.size(), MAXD);
        run(50);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int wd;
        for (wd = 0; wd < 20000; wd++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog cycle=%0d actual=%0d expected=%0d", cyc, wd, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule